// File: doc/BRIEF.md
# Conflict-Miss Victim Buffer

This block is a small fully associative store that sits next to a direct-mapped data cache. It holds lines that the direct-mapped array has thrown out. When the main cache misses, the controller presents the full line address here. If one of the held lines matches, that line is handed back to the controller. In the same operation, the line that the refill displaces from the direct-mapped slot takes over the freed entry, so the two lines trade places. If nothing matches, the block sends a read request to the next memory level. The main cache keeps its single-probe hit path, and lines that bounce between two addresses of the same set stop costing a trip to memory.

Lines enter the buffer only through the insert port, when the direct-mapped cache evicts them. An insert fills the lowest empty entry. When every entry is occupied, it overwrites the oldest one, chosen by a wrapping pointer. If the overwritten line is modified, its address and data go out as a write request to the next level. The buffer has a single request register toward memory. While that register holds a request, the buffer reports itself busy and ignores new lookups and inserts.

Top module: `victim_buffer`

## Requirements
- R1: After reset, rsp_valid, mem_req_valid and busy are 0 and every entry is empty, so the first lookup of any address misses.
- R2: A lookup that is accepted (lk_valid high while busy is low) gives a one-cycle pulse on rsp_valid in the cycle after it. The pulse comes with rsp_hit, rsp_way, rsp_data and rsp_dirty as the entry held them before the lookup.
- R3: A hit needs an equal full line address (all LINE_ADDR_W bits) in a valid entry. The default depth is 4 entries, and rsp_way is that entry's index from 0 to 3.
- R4: On a hit with lk_put_valid = 1, the hit entry takes lk_put_addr, lk_put_data and lk_put_dirty and stays valid. On a hit with lk_put_valid = 0, the hit entry becomes empty.
- R5: On a miss, in the cycle after the lookup, mem_req_valid = 1 and mem_req_write = 0 (read), with mem_req_addr equal to the looked-up address. The stored entries do not change, and the lk_put fields are ignored.
- R6: An insert uses the lowest-indexed empty entry and leaves the replacement pointer alone. When all entries are valid, it overwrites the entry at the pointer, which starts at 0 after reset and then advances by one, wrapping modulo the depth.
- R7: An insert that overwrites a valid entry with its dirty flag set raises, in the next cycle, mem_req_valid with mem_req_write = 1 (write), carrying the old line's address and data. Overwriting a clean entry issues no request.
- R8: mem_req_valid and its address, op and data stay stable until a cycle with mem_req_ready = 1, after which they drop. While mem_req_valid is 1, busy is 1, and any lookup or insert is ignored.
- R9: When lk_valid and ins_valid are both high in an accepted cycle, the lookup is served and the insert is dropped.
- R10: On a miss response, rsp_way and rsp_data are 0 and rsp_dirty is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request from the cache controller |
| lk_addr | input | LINE_ADDR_W | Full line address to search |
| lk_put_valid | input | 1 | A displaced direct-mapped line accompanies the lookup |
| lk_put_addr | input | LINE_ADDR_W | Line address of the displaced line |
| lk_put_data | input | LINE_W | Data of the displaced line |
| lk_put_dirty | input | 1 | Displaced line is modified |
| ins_valid | input | 1 | Insert a line evicted from the direct-mapped cache |
| ins_addr | input | LINE_ADDR_W | Line address of the evicted line |
| ins_data | input | LINE_W | Data of the evicted line |
| ins_dirty | input | 1 | Evicted line is modified |
| busy | output | 1 | A request toward memory is pending; lookups and inserts are ignored |
| rsp_valid | output | 1 | Lookup result pulse |
| rsp_hit | output | 1 | Lookup found the line |
| rsp_way | output | IDX_W | Index of the matching entry |
| rsp_data | output | LINE_W | Line data on a hit |
| rsp_dirty | output | 1 | Dirty flag of the returned line |
| mem_req_valid | output | 1 | Request toward the next level is pending |
| mem_req_write | output | 1 | 1 = write-back, 0 = line read |
| mem_req_addr | output | LINE_ADDR_W | Request line address |
| mem_req_data | output | LINE_W | Write-back data (0 for reads) |
| mem_req_ready | input | 1 | Next level accepts the pending request |

## Verification
Every result arrives exactly one rising edge after the input that causes it. The lookup response, the miss read request and the dirty write-back request all appear in the cycle after the accepting edge. The bench drives each stimulus at a falling edge, lets one rising edge pass, and checks at the next falling edge. In that way it samples the registered outputs in the first cycle they are due and never at the edge where they change. While a request waits for mem_req_ready, the bench checks at each falling edge that the request stays stable. It also sends a lookup and an insert into the busy window and confirms at the following falling edge that neither one had any effect.

// File: rtl/vb_pkg.sv
package vb_pkg;

    typedef enum logic {
        MEM_READ  = 1'b0,
        MEM_WRITE = 1'b1
    } mem_op_e;

    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match #(
    parameter int N  = 4,
    parameter int AW = 26,
    parameter int IW = 2
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        key,
    output logic                 hit,
    output logic [IW-1:0]        way
);
    logic [N-1:0] eq;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign eq[i] = vld[i] && (tags[i] == key);
    end

    always_comb begin
        hit = |eq;
        way = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) way = IW'(i);
        end
    end
endmodule

// File: rtl/vb_alloc.sv
module vb_alloc #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vld,
    input  logic [IW-1:0] ptr,
    output logic [IW-1:0] slot,
    output logic          full
);
    always_comb begin
        full = &vld;
        slot = ptr;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) slot = IW'(i);
        end
    end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import vb_pkg::*;
#(
    parameter int ENTRIES     = 4,
    parameter int LINE_ADDR_W = 26,
    parameter int LINE_W      = 128,
    localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [LINE_ADDR_W-1:0] lk_addr,
    input  logic                   lk_put_valid,
    input  logic [LINE_ADDR_W-1:0] lk_put_addr,
    input  logic [LINE_W-1:0]      lk_put_data,
    input  logic                   lk_put_dirty,
    input  logic                   ins_valid,
    input  logic [LINE_ADDR_W-1:0] ins_addr,
    input  logic [LINE_W-1:0]      ins_data,
    input  logic                   ins_dirty,
    output logic                   busy,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [IDX_W-1:0]       rsp_way,
    output logic [LINE_W-1:0]      rsp_data,
    output logic                   rsp_dirty,
    output logic                   mem_req_valid,
    output logic                   mem_req_write,
    output logic [LINE_ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0]      mem_req_data,
    input  logic                   mem_req_ready
);
    typedef struct packed {
        logic [ENTRIES-1:0]                  vld;
        logic [ENTRIES-1:0]                  dty;
        logic [ENTRIES-1:0][LINE_ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][LINE_W-1:0]      dat;
        logic [IDX_W-1:0]                    ptr;
        logic                                rsp_v;
        logic                                rsp_hit;
        logic [IDX_W-1:0]                    rsp_way;
        logic [LINE_W-1:0]                   rsp_data;
        logic                                rsp_dirty;
        logic                                req_v;
        mem_op_e                             req_op;
        logic [LINE_ADDR_W-1:0]              req_addr;
        logic [LINE_W-1:0]                   req_data;
    } state_t;

    state_t s_q, s_d;

    logic             hit_w;
    logic [IDX_W-1:0] way_w;
    logic [IDX_W-1:0] slot_w;
    logic             full_w;

    vb_match #(.N(ENTRIES), .AW(LINE_ADDR_W), .IW(IDX_W)) u_match (
        .vld  (s_q.vld),
        .tags (s_q.tag),
        .key  (lk_addr),
        .hit  (hit_w),
        .way  (way_w)
    );

    vb_alloc #(.N(ENTRIES), .IW(IDX_W)) u_alloc (
        .vld  (s_q.vld),
        .ptr  (s_q.ptr),
        .slot (slot_w),
        .full (full_w)
    );

    logic accept;
    assign accept = !s_q.req_v;

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;

        // Pending request retires on handshake
        if (s_q.req_v && mem_req_ready) begin
            s_d.req_v = 1'b0;
        end

        if (accept && lk_valid) begin
            // Lookup wins over a simultaneous insert
            s_d.rsp_v     = 1'b1;
            s_d.rsp_hit   = hit_w;
            s_d.rsp_way   = hit_w ? way_w : '0;
            s_d.rsp_data  = hit_w ? s_q.dat[way_w] : '0;
            s_d.rsp_dirty = hit_w ? s_q.dty[way_w] : 1'b0;
            if (hit_w) begin
                if (lk_put_valid) begin
                    s_d.vld[way_w] = 1'b1;
                    s_d.dty[way_w] = lk_put_dirty;
                    s_d.tag[way_w] = lk_put_addr;
                    s_d.dat[way_w] = lk_put_data;
                end else begin
                    s_d.vld[way_w] = 1'b0;
                    s_d.dty[way_w] = 1'b0;
                end
            end else begin
                s_d.req_v    = 1'b1;
                s_d.req_op   = MEM_READ;
                s_d.req_addr = lk_addr;
                s_d.req_data = '0;
            end
        end else if (accept && ins_valid) begin
            if (full_w) begin
                s_d.ptr = IDX_W'(wrap_inc(int'(s_q.ptr), ENTRIES));
                if (s_q.dty[slot_w]) begin
                    s_d.req_v    = 1'b1;
                    s_d.req_op   = MEM_WRITE;
                    s_d.req_addr = s_q.tag[slot_w];
                    s_d.req_data = s_q.dat[slot_w];
                end
            end
            s_d.vld[slot_w] = 1'b1;
            s_d.dty[slot_w] = ins_dirty;
            s_d.tag[slot_w] = ins_addr;
            s_d.dat[slot_w] = ins_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy          = s_q.req_v;
    assign rsp_valid     = s_q.rsp_v;
    assign rsp_hit       = s_q.rsp_hit;
    assign rsp_way       = s_q.rsp_way;
    assign rsp_data      = s_q.rsp_data;
    assign rsp_dirty     = s_q.rsp_dirty;
    assign mem_req_valid = s_q.req_v;
    assign mem_req_write = (s_q.req_op == MEM_WRITE);
    assign mem_req_addr  = s_q.req_addr;
    assign mem_req_data  = s_q.req_data;
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
    parameter int LINE_ADDR_W = 26,
    parameter int LINE_W      = 128,
    parameter int IDX_W       = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic [LINE_ADDR_W-1:0] lk_addr,
    input logic                   busy,
    input logic                   rsp_valid,
    input logic                   rsp_hit,
    input logic [IDX_W-1:0]       rsp_way,
    input logic [LINE_W-1:0]      rsp_data,
    input logic                   rsp_dirty,
    input logic                   mem_req_valid,
    input logic                   mem_req_write,
    input logic [LINE_ADDR_W-1:0] mem_req_addr,
    input logic [LINE_W-1:0]      mem_req_data,
    input logic                   mem_req_ready
);
    assert_rsp_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(lk_valid && !busy));

    assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rsp_valid);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_data)));

    assert_miss_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (mem_req_valid && !mem_req_write && mem_req_addr == $past(lk_addr)));

    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_way == '0 && rsp_data == '0 && !rsp_dirty));
endmodule

bind victim_buffer vb_checker #(
    .LINE_ADDR_W (LINE_ADDR_W),
    .LINE_W      (LINE_W),
    .IDX_W       (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_addr       (lk_addr),
    .busy          (busy),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_way       (rsp_way),
    .rsp_data      (rsp_data),
    .rsp_dirty     (rsp_dirty),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_data  (mem_req_data),
    .mem_req_ready (mem_req_ready)
);

// File: tb/sim_victim_buffer.sv
`timescale 1ns/1ps
module sim_victim_buffer;
    localparam int N  = 4;
    localparam int A  = 26;
    localparam int L  = 128;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, lk_put_valid = 0, lk_put_dirty = 0;
    logic [A-1:0] lk_addr = '0, lk_put_addr = '0, ins_addr = '0;
    logic [L-1:0] lk_put_data = '0, ins_data = '0;
    logic ins_valid = 0, ins_dirty = 0, mem_req_ready = 0;
    logic busy, rsp_valid, rsp_hit, rsp_dirty, mem_req_valid, mem_req_write;
    logic [IW-1:0] rsp_way;
    logic [L-1:0] rsp_data, mem_req_data;
    logic [A-1:0] mem_req_addr;

    always #2 clk = ~clk;

    victim_buffer #(.ENTRIES(N), .LINE_ADDR_W(A), .LINE_W(L)) u0 (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    bit         m_vld [N];
    bit         m_dty [N];
    logic [A-1:0] m_tag [N];
    logic [L-1:0] m_dat [N];
    int         m_ptr;

    task automatic chk(input bit ok, input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int m_find(input logic [A-1:0] a);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == a) return i;
        return -1;
    endfunction

    function automatic int m_slot(output bit full);
        full = 1;
        for (int i = 0; i < N; i++) if (!m_vld[i]) begin full = 0; return i; end
        return m_ptr;
    endfunction

    function automatic logic [L-1:0] rnd_line();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    function automatic logic [A-1:0] pool_addr();
        return A'(26'h1000 + ($urandom() % 12));
    endfunction

    function automatic logic [A-1:0] absent_addr(input logic [A-1:0] avoid);
        logic [A-1:0] a;
        for (int t = 0; t < 100; t++) begin
            a = pool_addr();
            if (m_find(a) < 0 && a != avoid) return a;
        end
        return A'(26'h2000 + ($urandom() % 64));
    endfunction

    // Hold a pending request for a few cycles, optionally poke the busy port, then grant.
    task automatic serve_mem(input bit exp_wr, input logic [A-1:0] exp_a, input logic [L-1:0] exp_d, input bit probe);
        int wait_n = $urandom() % 3;
        chk(mem_req_valid === 1'b1, "R8 request raised", L'(mem_req_valid), 1);
        chk(busy === 1'b1, "R8 busy with request", L'(busy), 1);
        chk(mem_req_write === exp_wr, exp_wr ? "R7 write op" : "R5 read op", L'(mem_req_write), L'(exp_wr));
        chk(mem_req_addr === exp_a, exp_wr ? "R7 write addr" : "R5 read addr", L'(mem_req_addr), L'(exp_a));
        chk(mem_req_data === exp_d, exp_wr ? "R7 write data" : "R5 read data", mem_req_data, exp_d);
        if (probe) begin
            // Lookup and insert while busy must be ignored
            lk_valid = 1; lk_addr = m_vld[0] ? m_tag[0] : pool_addr(); lk_put_valid = 0;
            ins_valid = 1; ins_addr = absent_addr('0); ins_data = rnd_line(); ins_dirty = 1;
            @(negedge clk);
            lk_valid = 0; ins_valid = 0;
            chk(rsp_valid === 1'b0, "R8 lookup ignored while busy", L'(rsp_valid), 0);
        end
        for (int k = 0; k < wait_n; k++) begin
            @(negedge clk);
            chk(mem_req_valid === 1'b1 && mem_req_addr === exp_a, "R8 request held",
                L'(mem_req_addr), L'(exp_a));
        end
        mem_req_ready = 1;
        @(negedge clk);
        mem_req_ready = 0;
        chk(mem_req_valid === 1'b0 && busy === 1'b0, "R8 request retired", L'(mem_req_valid), 0);
    endtask

    task automatic do_lookup(input logic [A-1:0] a, input bit pv, input logic [A-1:0] pa,
                             input logic [L-1:0] pd, input bit pdt, input bit also_ins,
                             input logic [A-1:0] ia, input bit probe);
        int idx = m_find(a);
        lk_valid = 1; lk_addr = a; lk_put_valid = pv; lk_put_addr = pa;
        lk_put_data = pd; lk_put_dirty = pdt;
        ins_valid = also_ins; ins_addr = ia; ins_data = rnd_line(); ins_dirty = 0;
        @(negedge clk);
        lk_valid = 0; lk_put_valid = 0; ins_valid = 0;
        chk(rsp_valid === 1'b1, "R2 response pulse", L'(rsp_valid), 1);
        chk(rsp_hit === (idx >= 0), "R3 hit flag", L'(rsp_hit), L'(idx >= 0));
        if (idx >= 0) begin
            chk(rsp_way === IW'(idx), "R3 way index", L'(rsp_way), L'(idx));
            chk(rsp_data === m_dat[idx], "R2 hit data", rsp_data, m_dat[idx]);
            chk(rsp_dirty === m_dty[idx], "R2 hit dirty", L'(rsp_dirty), L'(m_dty[idx]));
            chk(mem_req_valid === 1'b0, "R2 no request on hit", L'(mem_req_valid), 0);
            if (pv) begin
                m_tag[idx] = pa; m_dat[idx] = pd; m_dty[idx] = pdt;
            end else begin
                m_vld[idx] = 0; m_dty[idx] = 0;
            end
        end else begin
            chk(rsp_way === '0 && rsp_data === '0 && rsp_dirty === 1'b0, "R10 miss outputs zero",
                rsp_data, '0);
            serve_mem(1'b0, a, '0, probe);
        end
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R2 single pulse", L'(rsp_valid), 0);
    endtask

    task automatic do_insert(input logic [A-1:0] a, input logic [L-1:0] d, input bit dt, input bit probe);
        bit full;
        int s = m_slot(full);
        bit wb = full && m_dty[s];
        logic [A-1:0] oa = m_tag[s];
        logic [L-1:0] od = m_dat[s];
        ins_valid = 1; ins_addr = a; ins_data = d; ins_dirty = dt;
        @(negedge clk);
        ins_valid = 0;
        chk(rsp_valid === 1'b0, "R6 insert gives no response", L'(rsp_valid), 0);
        if (wb) serve_mem(1'b1, oa, od, probe);
        else chk(mem_req_valid === 1'b0, "R7 no request for clean or empty slot", L'(mem_req_valid), 0);
        m_vld[s] = 1; m_dty[s] = dt; m_tag[s] = a; m_dat[s] = d;
        if (full) m_ptr = (m_ptr + 1) % N;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_dty[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
        m_ptr = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", L'(rsp_valid), 0);
        chk(mem_req_valid === 1'b0, "R1 mem_req_valid after reset", L'(mem_req_valid), 0);
        chk(busy === 1'b0, "R1 busy after reset", L'(busy), 0);

        // R1: empty buffer misses; R5/R10 miss path
        do_lookup(26'h1000, 1, 26'h1001, rnd_line(), 1, 0, '0, 0);
        chk(m_find(26'h1001) < 0, "R5 put ignored on miss (model)", 0, 0);
        // R6: fill lowest empty first
        do_insert(26'h1001, rnd_line(), 0, 0);
        do_insert(26'h1002, rnd_line(), 1, 0);
        do_insert(26'h1003, rnd_line(), 0, 0);
        do_insert(26'h1004, rnd_line(), 0, 0);
        // R5: put fields ignored on miss; next lookup of put address misses
        do_lookup(26'h1005, 1, 26'h1006, rnd_line(), 0, 0, '0, 0);
        do_lookup(26'h1006, 0, '0, '0, 0, 0, '0, 0);
        // R6/R7: full buffer, pointer 0 holds a clean line, pointer 1 a dirty one
        do_insert(26'h1007, rnd_line(), 0, 0);
        do_insert(26'h1008, rnd_line(), 0, 1);
        // R4: swap on hit, then hit the swapped-in dirty line without a put
        do_lookup(26'h1003, 1, 26'h1009, rnd_line(), 1, 0, '0, 0);
        do_lookup(26'h1009, 0, '0, '0, 0, 0, '0, 0);
        do_lookup(26'h1009, 0, '0, '0, 0, 0, '0, 0);
        // R6: freed entry is reused before the pointer
        do_insert(26'h100a, rnd_line(), 1, 0);
        // R9: simultaneous lookup and insert; insert dropped
        do_lookup(26'h1004, 1, 26'h100b, rnd_line(), 0, 1, 26'h1000, 0);
        do_lookup(26'h1000, 0, '0, '0, 0, 0, '0, 1);
        // R6/R7: pointer wraps
        for (int i = 0; i < 6; i++) do_insert(absent_addr('0), rnd_line(), i[0], 1);

        for (int it = 0; it < 400; it++) begin
            int kind = $urandom() % 3;
            bit pr = ($urandom() % 4) == 0;
            if (kind == 0) begin
                do_insert(absent_addr('0), rnd_line(), $urandom() % 2, pr);
            end else begin
                logic [A-1:0] a = (kind == 1 && m_vld[$urandom() % N]) ? m_tag[$urandom() % N] : pool_addr();
                bit pv = $urandom() % 2;
                do_lookup(a, pv, absent_addr(a), rnd_line(), $urandom() % 2, 0, '0, pr);
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule